// File: doc/BRIEF.md
# Descriptor Access-Flag and Dirty-State Updater

This unit runs once an access has cleared its permission check. It looks at the translation descriptor that maps the page and decides whether the tracking bits in it must change. The access flag records that the page has been touched. Dirty state is kept by reusing the read-only permission bit. When a bit must change and hardware management is enabled, the unit issues a single write of the modified descriptor through a simple write port and waits for the acknowledge. Otherwise it reports a fault so that software can make the change.

A request carries the descriptor word, the address it was read from, whether the access is a write, and two enables: hardware access-flag update and hardware dirty tracking. The unit steps through four states. **IDLE** accepts a request. **EVAL** decides the outcome. **WRITE** holds the write port until the acknowledge arrives. **DONE** pulses the completion signal with a 2-bit status.

The transitions are:
- IDLE→EVAL when a request is accepted.
- EVAL→WRITE when the descriptor changes.
- EVAL→DONE when the descriptor is unchanged or the access faulted.
- WRITE→DONE on the write acknowledge.
- DONE→IDLE unconditionally.

Descriptor fields: the access flag is bit 10, the read-only bit is bit 7 and the dirty-bit-modifier is bit 51.

Top module: `desc_track_update`

## Requirements
- R1: After reset the unit is in IDLE: `req_ready` is 1 and `done` and `wr_valid` are 0.
- R2: If access flag (bit 10) is 0 and hardware access-flag update is off, status is 01 (access-flag fault) and no write is issued; this takes priority over a permission fault.
- R3: If access flag is 0, hardware access-flag update is on and no permission fault applies, exactly one write is issued with bit 10 set and status is 00 (ok).
- R4: A write access to a page with read-only bit (bit 7) set, dirty-bit-modifier (bit 51) set and hardware dirty tracking on issues a write with bit 7 cleared and reports status 00.
- R5: A write access to a page with bit 7 set and either bit 51 clear or hardware dirty tracking off reports status 10 (permission fault) and issues no write, even when the access flag would otherwise have been set.
- R6: A write access that both first-touches and dirties a page sets bit 10 and clears bit 7 in one single write.
- R7: When no bit would change, no write is issued and `done` rises in the second cycle after the request is accepted.
- R8: While `wr_valid` is high and unacknowledged, `wr_data` and `wr_addr` hold steady. `wr_addr` equals the request address and all untouched descriptor bits are preserved. `done` rises in the cycle after the acknowledge.
- R9: `done` is a one-cycle pulse, and `req_ready` is low from acceptance until after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Unit is idle and will accept a request |
| req_desc | input | DESC_W | Descriptor word as read |
| req_addr | input | AW | Address of the descriptor |
| req_is_write | input | 1 | Access is a write |
| hw_af_en | input | 1 | Hardware access-flag update enable |
| hw_dirty_en | input | 1 | Hardware dirty tracking enable |
| wr_valid | output | 1 | Write-back request |
| wr_addr | output | AW | Write-back address |
| wr_data | output | DESC_W | Modified descriptor |
| wr_ack | input | 1 | Write-back accepted |
| done | output | 1 | Completion pulse |
| done_status | output | 2 | 00 ok, 01 access-flag fault, 10 permission fault |

## Verification
The hardest situation to reach is the combined case. It needs a write to a page that is untouched, read-only and marked dirty-tracked, with both hardware enables on. It must yield a single write carrying both changes, while its near neighbours fault instead. The bench aims directed cases at each combination of the three descriptor bits and the two enables. It adds random descriptors where those bits are drawn independently. It also stretches the acknowledge by random delays, so the hold of the write port and the late completion are exercised.

// File: rtl/desc_upd_pkg.sv
package desc_upd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } upd_state_t;

    typedef enum logic [1:0] {
        STS_OK         = 2'b00,
        STS_AF_FAULT   = 2'b01,
        STS_PERM_FAULT = 2'b10
    } upd_status_t;
endpackage

// File: rtl/desc_upd_rule.sv
module desc_upd_rule
    import desc_upd_pkg::*;
#(
    parameter int DESC_W  = 64,
    parameter int AF_BIT  = 10,
    parameter int RO_BIT  = 7,
    parameter int DBM_BIT = 51
) (
    input  logic [DESC_W-1:0] desc_in,
    input  logic              is_write,
    input  logic              hw_af_en,
    input  logic              hw_dirty_en,
    output upd_status_t       status,
    output logic [DESC_W-1:0] desc_out,
    output logic              need_write
);
    logic untouched;
    logic read_only;
    logic dirty_ok;
    logic af_fault;
    logic perm_fault;

    always_comb begin
        untouched  = ~desc_in[AF_BIT];
        read_only  = desc_in[RO_BIT];
        dirty_ok   = desc_in[DBM_BIT] & hw_dirty_en;
        af_fault   = untouched & ~hw_af_en;
        perm_fault = is_write & read_only & ~dirty_ok;

        desc_out = desc_in;
        if (af_fault) begin
            status = STS_AF_FAULT;
        end else if (perm_fault) begin
            status = STS_PERM_FAULT;
        end else begin
            status = STS_OK;
            if (untouched) begin
                desc_out[AF_BIT] = 1'b1;
            end
            if (is_write && read_only) begin
                desc_out[RO_BIT] = 1'b0;
            end
        end
        need_write = (desc_out != desc_in);
    end
endmodule

// File: rtl/desc_upd_ctrl.sv
module desc_upd_ctrl
    import desc_upd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       need_write,
    input  logic       wr_ack,
    output logic       req_ready,
    output logic       capture,
    output logic       eval_load,
    output logic       wr_valid,
    output logic       done
);
    upd_state_t state_q;
    upd_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_EVAL;
            ST_EVAL:  state_d = need_write ? ST_WRITE : ST_DONE;
            ST_WRITE: if (wr_ack) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        capture   = 1'b0;
        eval_load = 1'b0;
        wr_valid  = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                capture   = req_valid;
            end
            ST_EVAL:  eval_load = 1'b1;
            ST_WRITE: wr_valid  = 1'b1;
            ST_DONE:  done      = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/desc_track_update.sv
module desc_track_update
    import desc_upd_pkg::*;
#(
    parameter int DESC_W  = 64,
    parameter int AW      = 40,
    parameter int AF_BIT  = 10,
    parameter int RO_BIT  = 7,
    parameter int DBM_BIT = 51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DESC_W-1:0] req_desc,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_is_write,
    input  logic              hw_af_en,
    input  logic              hw_dirty_en,
    output logic              wr_valid,
    output logic [AW-1:0]     wr_addr,
    output logic [DESC_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              done,
    output logic [1:0]        done_status
);
    logic [DESC_W-1:0] desc_q;
    logic [AW-1:0]     addr_q;
    logic              is_write_q;
    logic              af_en_q;
    logic              dirty_en_q;
    logic [DESC_W-1:0] new_q;
    upd_status_t       status_q;

    upd_status_t       rule_status;
    logic [DESC_W-1:0] rule_desc;
    logic              rule_need;
    logic              capture;
    logic              eval_load;

    desc_upd_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .need_write (rule_need),
        .wr_ack     (wr_ack),
        .req_ready  (req_ready),
        .capture    (capture),
        .eval_load  (eval_load),
        .wr_valid   (wr_valid),
        .done       (done)
    );

    desc_upd_rule #(
        .DESC_W  (DESC_W),
        .AF_BIT  (AF_BIT),
        .RO_BIT  (RO_BIT),
        .DBM_BIT (DBM_BIT)
    ) u_rule (
        .desc_in     (desc_q),
        .is_write    (is_write_q),
        .hw_af_en    (af_en_q),
        .hw_dirty_en (dirty_en_q),
        .status      (rule_status),
        .desc_out    (rule_desc),
        .need_write  (rule_need)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q     <= '0;
            addr_q     <= '0;
            is_write_q <= 1'b0;
            af_en_q    <= 1'b0;
            dirty_en_q <= 1'b0;
        end else if (capture) begin
            desc_q     <= req_desc;
            addr_q     <= req_addr;
            is_write_q <= req_is_write;
            af_en_q    <= hw_af_en;
            dirty_en_q <= hw_dirty_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            new_q    <= '0;
            status_q <= STS_OK;
        end else if (eval_load) begin
            new_q    <= rule_desc;
            status_q <= rule_status;
        end
    end

    assign wr_addr     = addr_q;
    assign wr_data     = new_q;
    assign done_status = status_q;
endmodule

// File: rtl/desc_track_update_chk.sv
module desc_track_update_chk #(
    parameter int DESC_W = 64,
    parameter int AF_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              wr_valid,
    input logic              wr_ack,
    input logic [DESC_W-1:0] wr_data,
    input logic [DESC_W-1:0] orig_desc,
    input logic              done,
    input logic [1:0]        done_status
);
    a_r8_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ack |=> wr_valid && $stable(wr_data));

    a_r7_write_only_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_data != orig_desc);

    a_r3_written_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_data[AF_BIT]);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    a_r5_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_status != 2'b00 |-> !$past(wr_valid));

    a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(wr_valid) |-> $past(wr_ack));

    a_r2_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> done_status != 2'b11);
endmodule

bind desc_track_update desc_track_update_chk #(
    .DESC_W (DESC_W),
    .AF_BIT (AF_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .wr_valid    (wr_valid),
    .wr_ack      (wr_ack),
    .wr_data     (wr_data),
    .orig_desc   (desc_q),
    .done        (done),
    .done_status (done_status)
);

// File: tb/test_desc_track_update.sv
module test_desc_track_update;
    localparam int DW = 64;
    localparam int AW = 40;
    localparam int AFB = 10;
    localparam int ROB = 7;
    localparam int DBMB = 51;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [DW-1:0] req_desc = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_is_write = 1'b0;
    logic          hw_af_en = 1'b0;
    logic          hw_dirty_en = 1'b0;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          wr_ack = 1'b0;
    logic          done;
    logic [1:0]    done_status;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    desc_track_update i_desc_track_update (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_desc (req_desc), .req_addr (req_addr), .req_is_write (req_is_write),
        .hw_af_en (hw_af_en), .hw_dirty_en (hw_dirty_en), .wr_valid (wr_valid),
        .wr_addr (wr_addr), .wr_data (wr_data), .wr_ack (wr_ack), .done (done),
        .done_status (done_status)
    );

    // {need_write, status, new descriptor}
    function automatic logic [DW+2:0] model(input logic [DW-1:0] d, input logic w,
                                            input logic afe, input logic de);
        logic [DW-1:0] n;
        logic [1:0] s;
        n = d;
        if (!d[AFB] && !afe) s = 2'b01;
        else if (w && d[ROB] && !(d[DBMB] && de)) s = 2'b10;
        else begin
            s = 2'b00;
            n[AFB] = 1'b1;
            if (w) n[ROB] = 1'b0;
        end
        return {n != d, s, n};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [DW-1:0] d, input logic w, input logic afe,
                           input logic de, input int ack_delay, input string tag);
        logic [DW+2:0] exp;
        logic [AW-1:0] a;
        int writes, hold, cyc, done_cyc, ack_cyc;
        bit got;
        exp = model(d, w, afe, de);
        a = {$urandom, $urandom};
        @(negedge clk);
        check(req_ready === 1'b1, "R9 ready before request", req_ready, 1);
        req_valid = 1'b1; req_desc = d; req_addr = a; req_is_write = w;
        hw_af_en = afe; hw_dirty_en = de;
        writes = 0; hold = 0; cyc = 0; got = 0; done_cyc = 0; ack_cyc = -1;
        while (!got && cyc < 60) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_desc = {$urandom, $urandom};
            wr_ack = 1'b0;
            cyc++;
            if (!done && req_ready) check(0, "R9 ready low while busy", req_ready, 0);
            if (wr_valid) begin
                if (hold == ack_delay) begin
                    writes++;
                    check(wr_data === exp[DW-1:0], {"R8 write data ", tag}, wr_data, exp[DW-1:0]);
                    check(wr_addr === a, "R8 write address", wr_addr, a);
                    wr_ack = 1'b1;
                    ack_cyc = cyc;
                    hold = 0;
                end else hold++;
            end
            if (done) begin
                got = 1;
                done_cyc = cyc;
            end
        end
        check(got, {"R9 done seen ", tag}, got, 1);
        check(done_status === exp[DW+1:DW], {"R2 R5 status ", tag}, done_status, exp[DW+1:DW]);
        check(writes == int'(exp[DW+2]), {"R3 R7 write count ", tag}, writes, exp[DW+2]);
        if (!exp[DW+2]) check(done_cyc == 2, "R7 latency without write", done_cyc, 2);
        else check(done_cyc == ack_cyc + 1, "R8 done after ack", done_cyc, ack_cyc + 1);
        @(negedge clk);
        check(!done, "R9 done pulse length", done, 0);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd4711);
        #2000000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] base;
        repeat (3) @(negedge clk);
        check(req_ready === 1'b1 && done === 1'b0 && wr_valid === 1'b0,
              "R1 reset state", {req_ready, done, wr_valid}, 3'b100);
        rst_n = 1'b1;
        base = 64'h00F0_0000_1234_5003;
        // directed corners: {AF, RO, DBM}
        run_one(base & ~(64'd1 << AFB), 1'b0, 1'b0, 1'b1, 0, "R2 af fault read");
        run_one((base & ~(64'd1 << AFB)) | (64'd1 << ROB), 1'b1, 1'b0, 1'b0, 0, "R2 af before perm");
        run_one(base & ~(64'd1 << AFB), 1'b0, 1'b1, 1'b0, 2, "R3 hw af set");
        run_one(base | (64'd1 << AFB) | (64'd1 << ROB) | (64'd1 << DBMB), 1'b1, 1'b0, 1'b1, 1, "R4 dirty");
        run_one(base | (64'd1 << AFB) | (64'd1 << ROB), 1'b1, 1'b1, 1'b1, 0, "R5 no dbm");
        run_one(base | (64'd1 << AFB) | (64'd1 << ROB) | (64'd1 << DBMB), 1'b1, 1'b1, 1'b0, 0, "R5 dirty off");
        run_one((base & ~(64'd1 << AFB)) | (64'd1 << ROB), 1'b1, 1'b1, 1'b1, 0, "R5 af not set on fault");
        run_one((base & ~(64'd1 << AFB)) | (64'd1 << ROB) | (64'd1 << DBMB), 1'b1, 1'b1, 1'b1, 3, "R6 combined");
        run_one(base | (64'd1 << AFB) | (64'd1 << ROB), 1'b0, 1'b0, 1'b0, 0, "R7 read ro");
        run_one(base | (64'd1 << AFB), 1'b1, 1'b1, 1'b1, 0, "R7 write rw");
        for (int i = 0; i < 200; i++) begin
            logic [DW-1:0] d;
            d = {$urandom, $urandom};
            run_one(d, 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 4), "random");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule